// File: doc/BRIEF.md
# Two-Wire Bus Control Unit

This block holds the control, data and own-address registers of a two-wire serial controller and turns the control bits into bus actions. It drives SCL and SDA through open-drain pull-low enables. It generates START and STOP conditions with a programmable hold time. It follows START and STOP conditions made by any master to know whether the bus is busy. It decides whether an acknowledge follows each received byte, and it raises an interrupt request.

A CPU writes the registers through single-cycle write strobes and reads them back on flat output buses. A separate byte shift engine reports each received byte with one strobe. With that strobe it sends three qualifiers: own-address match, general-call match, and data byte received while acting as a receiver. The shift engine takes the acknowledge decision back from `ack_drive`. While the block is selected as a slave and its interrupt flag is set, it stretches the clock by holding SCL low.

Control register layout: bit 7 interrupt flag (write 1 to clear), bit 6 acknowledge enable, bit 5 START request, bit 4 STOP request, bit 3 write collision (read-only), bit 2 interface enable, bit 1 reserved, bit 0 interrupt enable. Own-address register: bits 7:1 slave address, bit 0 general-call recognition enable.

Top module: `tw_bus_ctl`

## Requirements
- R1: After reset the control readback is 0x00, the data readback is 0x00, neither pull-low enable is active, and `irq`, `ack_drive` and `bus_busy` are 0.
- R2: With enable (bit 2) and START request (bit 5) set on an idle bus, SDA is pulled low for exactly HOLD_CLKS cycles while SCL is released. After that both lines are held low and the interrupt flag (bit 7) is set.
- R3: `bus_busy` rises after SDA falls while SCL is high and falls after SDA rises while SCL is high. A START request made while the bus is busy drives nothing until a STOP is seen, and then the START is generated.
- R4: The START request bit stays 1 after the START has completed, until the CPU writes it to 0.
- R5: A STOP request (bit 4) while master releases SCL first and holds SDA low for exactly HOLD_CLKS more cycles before releasing it. The STOP bit then reads 0 and the interrupt flag is not set by the STOP.
- R6: A STOP request while not master never pulls SDA low. Within two cycles of the write it clears the STOP bit, drops the slave selection (which releases a stretched SCL) and clears `ack_drive`.
- R7: On a received-byte strobe with acknowledge enable (bit 6) set, `ack_drive` becomes 1 in the next cycle when the address matched, or a general call arrived while own-address bit 0 is 1, or a data byte was received; otherwise it becomes 0.
- R8: With acknowledge enable at 0, `ack_drive` is 0 after every strobe. Writing bit 6 back to 1 makes the next address match acknowledged again.
- R9: A data-register write while the interrupt flag is 0 sets the collision bit (bit 3) and leaves the data register unchanged. A data write while the flag is 1 stores the byte and clears the collision bit.
- R10: Writing enable to 0 while master releases SCL and SDA at once, and `bus_busy` reads 0 in the following cycle.
- R11: Control bit 1 always reads 0, whatever is written to it.
- R12: `irq` is 1 exactly when the interrupt flag, the interrupt enable (bit 0) and `glb_irq_en` are all 1.
- R13: A received-byte strobe while enabled sets the interrupt flag. A control write with bit 7 set clears it. While the block is selected as a slave and the flag is 1, SCL is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_ctl | input | 1 | Control register write strobe |
| cpu_wr_dat | input | 1 | Data register write strobe |
| cpu_wr_own | input | 1 | Own-address register write strobe |
| cpu_wdata | input | 8 | CPU write data |
| ctl_rd | output | 8 | Control register readback |
| dat_rd | output | 8 | Data register readback |
| own_addr | output | 7 | Own slave address for the shift engine |
| glb_irq_en | input | 1 | Global interrupt enable |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drv_low | output | 1 | Pull SCL low when 1 |
| sda_drv_low | output | 1 | Pull SDA low when 1 |
| bus_busy | output | 1 | Bus held by some master |
| rx_byte_vld | input | 1 | One-cycle received-byte strobe |
| rx_addr_hit | input | 1 | Byte matched own address |
| rx_gcall_hit | input | 1 | Byte was a general call |
| rx_data_byte | input | 1 | Byte was data received as receiver |
| ack_drive | output | 1 | Acknowledge decision for the last byte |
| irq | output | 1 | Interrupt request |

## Verification
A wrong condition-generator state shows at the pull-low enables within one cycle of the state change. A START with SCL low first, or a STOP that releases SDA early, changes the counted low interval of HOLD_CLKS cycles on the looped-back bus. A stale busy bit shows as a START that never leaves or leaves too early, so the bench drives a foreign START and STOP on the wired bus and watches SDA. A wrong acknowledge or flag decision shows in `ack_drive`, `irq` or the readback one cycle after the strobe. For that reason the acknowledge and interrupt gating are swept over every input combination.

// File: rtl/tw_pkg.sv
// Shared definitions for the two-wire bus control unit.
// Assumes an 8-bit CPU register port.
package tw_pkg;
    localparam int B_IFLG  = 7;
    localparam int B_ACKEN = 6;
    localparam int B_STA   = 5;
    localparam int B_STO   = 4;
    localparam int B_WCOL  = 3;
    localparam int B_EN    = 2;
    localparam int B_RSV   = 1;
    localparam int B_IE    = 0;

    typedef enum logic [1:0] {
        G_IDLE  = 2'd0,
        G_START = 2'd1,
        G_OWN   = 2'd2,
        G_STOP  = 2'd3
    } gen_state_e;
endpackage

// File: rtl/tw_line_watch.sv
// Bus line watcher: synchronises SCL/SDA with two flops each and tracks
// bus occupancy from START (SDA falls, SCL high) and STOP (SDA rises,
// SCL high). Assumes released lines read 1. Cleared while disabled.
module tw_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy
);
    logic [1:0] scl_sy;
    logic [1:0] sda_sy;
    logic       sda_prev;
    logic       seen_start;
    logic       seen_stop;

    // Two-stage synchronisers plus one history stage on SDA.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sy   <= 2'b11;
            sda_sy   <= 2'b11;
            sda_prev <= 1'b1;
        end else begin
            scl_sy   <= {scl_sy[0], scl_in};
            sda_sy   <= {sda_sy[0], sda_in};
            sda_prev <= sda_sy[1];
        end
    end

    // Edge classification of SDA while SCL is high.
    always_comb begin
        seen_start = scl_sy[1] &  sda_prev & ~sda_sy[1];
        seen_stop  = scl_sy[1] & ~sda_prev &  sda_sy[1];
    end

    // Occupancy flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            busy <= 1'b0;
        end else if (seen_start) begin
            busy <= 1'b1;
        end else if (seen_stop) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/tw_cond_gen.sv
// START/STOP condition generator. START: SDA low for HOLD_CLKS cycles with
// SCL released, then both held low (master owns bus). STOP: SCL released,
// SDA released HOLD_CLKS cycles later. A STOP request while not master is
// reported as a slave reset and drives nothing. Assumes HOLD_CLKS >= 1.
module tw_cond_gen #(
    parameter int HOLD_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_req,
    input  logic stop_req,
    input  logic bus_busy,
    output logic scl_low,
    output logic sda_low,
    output logic start_done,
    output logic stop_done,
    output logic slave_reset
);
    import tw_pkg::*;

    localparam int CW = (HOLD_CLKS < 2) ? 1 : $clog2(HOLD_CLKS);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CLKS - 1);

    gen_state_e     state;
    logic [CW-1:0]  cnt;
    logic           hold_end;

    // Hold-interval end marker shared by START and STOP.
    always_comb hold_end = (cnt == LAST);

    // Sequencer: state and hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= G_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                G_IDLE: begin
                    cnt <= '0;
                    if (!stop_req && start_req && !bus_busy) begin
                        state <= G_START;
                    end
                end
                G_START: begin
                    if (hold_end) begin
                        state <= G_OWN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                G_OWN: begin
                    cnt <= '0;
                    if (stop_req) begin
                        state <= G_STOP;
                    end
                end
                G_STOP: begin
                    if (hold_end) begin
                        state <= G_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= G_IDLE;
            endcase
        end
    end

    // Line drives and event pulses, all gated by the enable.
    always_comb begin
        sda_low     = enable && (state != G_IDLE);
        scl_low     = enable && (state == G_OWN);
        start_done  = enable && (state == G_START) && hold_end;
        slave_reset = enable && (state == G_IDLE) && stop_req;
        stop_done   = slave_reset || (enable && (state == G_STOP) && hold_end);
    end
endmodule

// File: rtl/tw_ctl_regs.sv
// CPU-visible registers: control, data and own address. The flag is set by
// hardware (set wins over a clearing write); the STOP bit is cleared by
// hardware unless the CPU writes control in the same cycle. Data writes
// are refused while the flag is low and mark a collision.
module tw_ctl_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctl,
    input  logic          wr_dat,
    input  logic          wr_own,
    input  logic [DW-1:0] wdata,
    input  logic          flag_set,
    input  logic          stop_clr,
    output logic [DW-1:0] ctl_q,
    output logic [DW-1:0] dat_q,
    output logic [DW-2:0] own_q,
    output logic          gc_en,
    output logic          f_flag,
    output logic          f_acken,
    output logic          f_sta,
    output logic          f_sto,
    output logic          f_en,
    output logic          f_ie
);
    import tw_pkg::*;

    logic f_wcol;

    // Control fields written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_acken <= 1'b0;
            f_sta   <= 1'b0;
            f_sto   <= 1'b0;
            f_en    <= 1'b0;
            f_ie    <= 1'b0;
        end else if (wr_ctl) begin
            f_acken <= wdata[B_ACKEN];
            f_sta   <= wdata[B_STA];
            f_sto   <= wdata[B_STO];
            f_en    <= wdata[B_EN];
            f_ie    <= wdata[B_IE];
        end else if (stop_clr) begin
            f_sto   <= 1'b0;
        end
    end

    // Interrupt flag: hardware set, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_flag <= 1'b0;
        end else if (flag_set) begin
            f_flag <= 1'b1;
        end else if (wr_ctl && wdata[B_IFLG]) begin
            f_flag <= 1'b0;
        end
    end

    // Data register with collision detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q  <= '0;
            f_wcol <= 1'b0;
        end else if (wr_dat) begin
            if (f_flag) begin
                dat_q  <= wdata;
                f_wcol <= 1'b0;
            end else begin
                f_wcol <= 1'b1;
            end
        end
    end

    // Own address and general-call recognition enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= '0;
            gc_en <= 1'b0;
        end else if (wr_own) begin
            own_q <= wdata[DW-1:1];
            gc_en <= wdata[0];
        end
    end

    // Readback assembly; reserved bit forced to zero.
    always_comb begin
        ctl_q          = '0;
        ctl_q[B_IFLG]  = f_flag;
        ctl_q[B_ACKEN] = f_acken;
        ctl_q[B_STA]   = f_sta;
        ctl_q[B_STO]   = f_sto;
        ctl_q[B_WCOL]  = f_wcol;
        ctl_q[B_EN]    = f_en;
        ctl_q[B_RSV]   = 1'b0;
        ctl_q[B_IE]    = f_ie;
    end
endmodule

// File: rtl/tw_bus_ctl.sv
// Two-wire bus control unit top: registers, line watcher, condition
// generator, acknowledge decision, slave clock stretch and interrupt.
// Assumes the shift engine gives one strobe per received byte.
module tw_bus_ctl #(
    parameter int HOLD_CLKS = 4,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr_ctl,
    input  logic          cpu_wr_dat,
    input  logic          cpu_wr_own,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] ctl_rd,
    output logic [DW-1:0] dat_rd,
    output logic [DW-2:0] own_addr,
    input  logic          glb_irq_en,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_drv_low,
    output logic          sda_drv_low,
    output logic          bus_busy,
    input  logic          rx_byte_vld,
    input  logic          rx_addr_hit,
    input  logic          rx_gcall_hit,
    input  logic          rx_data_byte,
    output logic          ack_drive,
    output logic          irq
);
    logic gc_en, f_flag, f_acken, f_sta, f_sto, f_en, f_ie;
    logic gen_scl_low, gen_sda_low, start_done, stop_done, slave_reset;
    logic byte_ev, addr_take, ack_take, slv_sel;

    tw_ctl_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_ctl(cpu_wr_ctl), .wr_dat(cpu_wr_dat), .wr_own(cpu_wr_own),
        .wdata(cpu_wdata),
        .flag_set(byte_ev || start_done), .stop_clr(stop_done),
        .ctl_q(ctl_rd), .dat_q(dat_rd), .own_q(own_addr), .gc_en(gc_en),
        .f_flag(f_flag), .f_acken(f_acken), .f_sta(f_sta), .f_sto(f_sto),
        .f_en(f_en), .f_ie(f_ie)
    );

    tw_line_watch u_watch (
        .clk(clk), .rst_n(rst_n), .enable(f_en),
        .scl_in(scl_in), .sda_in(sda_in), .busy(bus_busy)
    );

    tw_cond_gen #(.HOLD_CLKS(HOLD_CLKS)) u_gen (
        .clk(clk), .rst_n(rst_n), .enable(f_en),
        .start_req(f_sta), .stop_req(f_sto), .bus_busy(bus_busy),
        .scl_low(gen_scl_low), .sda_low(gen_sda_low),
        .start_done(start_done), .stop_done(stop_done),
        .slave_reset(slave_reset)
    );

    // Acknowledge and slave-selection decision for the current byte.
    always_comb begin
        byte_ev   = rx_byte_vld && f_en;
        addr_take = rx_addr_hit || (rx_gcall_hit && gc_en);
        ack_take  = f_acken && (addr_take || rx_data_byte);
    end

    // Latched acknowledge and slave selection; dropped by slave reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !f_en || slave_reset) begin
            ack_drive <= 1'b0;
            slv_sel   <= 1'b0;
        end else if (byte_ev) begin
            ack_drive <= ack_take;
            if (f_acken && addr_take) begin
                slv_sel <= 1'b1;
            end
        end
    end

    // Line drives and interrupt request.
    always_comb begin
        scl_drv_low = gen_scl_low || (f_en && slv_sel && f_flag);
        sda_drv_low = gen_sda_low;
        irq         = f_flag && f_ie && glb_irq_en;
    end
endmodule

// File: rtl/tw_bus_ctl_chk.sv
// Assertion checker for tw_bus_ctl, attached by bind below.
module tw_bus_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctl_rd,
    input logic [7:0] dat_rd,
    input logic       cpu_wr_dat,
    input logic       scl_drv_low,
    input logic       sda_drv_low,
    input logic       bus_busy,
    input logic       rx_byte_vld,
    input logic       ack_drive
);
    AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rd[2] |-> (!scl_drv_low && !sda_drv_low)); // R10

    AST_WCOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_dat && !ctl_rd[7]) |=> (ctl_rd[3] && $stable(dat_rd))); // R9

    AST_ACK_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_vld && !ctl_rd[6]) |=> !ack_drive); // R8

    AST_SDA_AFTER_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drv_low) |-> !scl_drv_low); // R5

    AST_START_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drv_low) |-> !$past(bus_busy)); // R3

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_rd[1]) == 1'b0); // R11
endmodule

bind tw_bus_ctl tw_bus_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_rd(ctl_rd), .dat_rd(dat_rd),
    .cpu_wr_dat(cpu_wr_dat), .scl_drv_low(scl_drv_low),
    .sda_drv_low(sda_drv_low), .bus_busy(bus_busy),
    .rx_byte_vld(rx_byte_vld), .ack_drive(ack_drive)
);

// File: tb/tb_tw_bus_ctl.sv
// Self-checking bench for tw_bus_ctl with a wired-AND bus loopback.
module tb_tw_bus_ctl;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_ctl = 1'b0, wr_dat = 1'b0, wr_own = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] ctl_rd, dat_rd;
    logic [6:0] own_addr;
    logic       gie = 1'b0;
    logic       ext_scl = 1'b1, ext_sda = 1'b1;
    logic       scl_in, sda_in, scl_drv_low, sda_drv_low, bus_busy;
    logic       rx_vld = 1'b0, rx_addr = 1'b0, rx_gc = 1'b0, rx_dat = 1'b0;
    logic       ack_drive, irq;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign scl_in = ext_scl & ~scl_drv_low;
    assign sda_in = ext_sda & ~sda_drv_low;

    tw_bus_ctl #(.HOLD_CLKS(HOLD)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_ctl(wr_ctl), .cpu_wr_dat(wr_dat), .cpu_wr_own(wr_own),
        .cpu_wdata(wdata), .ctl_rd(ctl_rd), .dat_rd(dat_rd),
        .own_addr(own_addr), .glb_irq_en(gie),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low),
        .bus_busy(bus_busy),
        .rx_byte_vld(rx_vld), .rx_addr_hit(rx_addr), .rx_gcall_hit(rx_gc),
        .rx_data_byte(rx_dat), .ack_drive(ack_drive), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_ctl(input logic [7:0] v);
        @(negedge clk); wr_ctl = 1'b1; wdata = v;
        @(negedge clk); wr_ctl = 1'b0;
    endtask

    task automatic cpu_dat(input logic [7:0] v);
        @(negedge clk); wr_dat = 1'b1; wdata = v;
        @(negedge clk); wr_dat = 1'b0;
    endtask

    task automatic cpu_own(input logic [7:0] v);
        @(negedge clk); wr_own = 1'b1; wdata = v;
        @(negedge clk); wr_own = 1'b0;
    endtask

    task automatic strobe(input logic a, input logic g, input logic d);
        @(negedge clk); rx_vld = 1'b1; rx_addr = a; rx_gc = g; rx_dat = d;
        @(negedge clk); rx_vld = 1'b0; rx_addr = 1'b0; rx_gc = 1'b0; rx_dat = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctl_rd == 8'h00, "R1 ctl", ctl_rd, 0);
        chk(dat_rd == 8'h00, "R1 dat", dat_rd, 0);
        chk({scl_drv_low, sda_drv_low, irq, ack_drive, bus_busy} == 5'b0, "R1 outs",
            {scl_drv_low, sda_drv_low, irq, ack_drive, bus_busy}, 0);

        // R11 reserved bit
        cpu_ctl(8'h43);
        chk(ctl_rd == 8'h41, "R11 rsv", ctl_rd, 8'h41);

        // R7 and R8 sweep of acknowledge qualifiers
        for (int i = 0; i < 32; i++) begin
            logic ge, a, ad, gc, rx, exp;
            {ge, a, ad, gc, rx} = 5'(i);
            cpu_own({7'h2A, ge});
            cpu_ctl(8'h84 | (8'(a) << 6));
            strobe(ad, gc, rx);
            exp = a & (ad | (gc & ge) | rx);
            chk(ack_drive == exp, a ? "R7 ack" : "R8 ack off", ack_drive, exp);
        end
        chk(own_addr == 7'h2A, "R7 own", own_addr, 7'h2A);

        // R8 re-enable resumes recognition
        cpu_ctl(8'h84);
        strobe(1'b1, 1'b0, 1'b0);
        chk(ack_drive == 1'b0, "R8 muted", ack_drive, 0);
        cpu_ctl(8'hC4);
        strobe(1'b1, 1'b0, 1'b0);
        chk(ack_drive == 1'b1, "R8 resumed", ack_drive, 1);

        // R13 flag set by strobe, stretch, clear by write
        chk(ctl_rd[7] == 1'b1, "R13 flag set", ctl_rd[7], 1);
        chk(scl_drv_low == 1'b1, "R13 stretch", scl_drv_low, 1);
        cpu_ctl(8'hC4);
        chk(ctl_rd[7] == 1'b0, "R13 flag clr", ctl_rd[7], 0);
        chk(scl_drv_low == 1'b0, "R13 unstretch", scl_drv_low, 0);

        // R6 slave-mode STOP request
        strobe(1'b1, 1'b0, 1'b0);
        chk(scl_drv_low && ack_drive, "R6 selected", {scl_drv_low, ack_drive}, 3);
        cpu_ctl(8'h54);
        n = sda_drv_low;
        @(negedge clk);
        n += sda_drv_low;
        chk(n == 0, "R6 no sda", n, 0);
        chk(ctl_rd[4] == 1'b0, "R6 sto clr", ctl_rd[4], 0);
        chk(!scl_drv_low && !ack_drive, "R6 release", {scl_drv_low, ack_drive}, 0);

        // R12 interrupt gating sweep
        for (int i = 0; i < 8; i++) begin
            logic f, ie, g;
            {f, ie, g} = 3'(i);
            cpu_ctl(8'h84 | 8'(ie));
            if (f) strobe(1'b0, 1'b0, 1'b0);
            gie = g;
            @(negedge clk);
            chk(irq == (f & ie & g), "R12 irq", irq, f & ie & g);
        end
        gie = 1'b0;

        // R9 write collision
        cpu_ctl(8'h84);
        cpu_dat(8'hA5);
        chk(ctl_rd[3] == 1'b1, "R9 wcol set", ctl_rd[3], 1);
        chk(dat_rd == 8'h00, "R9 dat kept", dat_rd, 0);
        strobe(1'b0, 1'b0, 1'b0);
        cpu_dat(8'h3C);
        chk(dat_rd == 8'h3C, "R9 dat store", dat_rd, 8'h3C);
        chk(ctl_rd[3] == 1'b0, "R9 wcol clr", ctl_rd[3], 0);

        // R2 START on idle bus
        cpu_ctl(8'hA4);
        n = 0;
        while (!sda_drv_low && n < 10) begin @(negedge clk); n++; end
        chk(sda_drv_low && !scl_drv_low, "R2 sda first", {scl_drv_low, sda_drv_low}, 1);
        n = 0;
        while (sda_drv_low && !scl_drv_low && n < 50) begin @(negedge clk); n++; end
        chk(n == HOLD, "R2 hold", n, HOLD);
        chk(scl_drv_low && sda_drv_low, "R2 both low", {scl_drv_low, sda_drv_low}, 3);
        chk(ctl_rd[7] == 1'b1, "R2 flag", ctl_rd[7], 1);
        repeat (10) @(negedge clk);
        chk(bus_busy == 1'b1, "R3 busy own", bus_busy, 1);
        chk(ctl_rd[5] == 1'b1, "R4 sta kept", ctl_rd[5], 1);
        chk(scl_drv_low && sda_drv_low, "R4 no restart", {scl_drv_low, sda_drv_low}, 3);

        // R5 master STOP
        cpu_ctl(8'h94);
        n = 0;
        while (scl_drv_low && n < 10) begin @(negedge clk); n++; end
        chk(sda_drv_low && !scl_drv_low, "R5 scl first", {scl_drv_low, sda_drv_low}, 1);
        n = 0;
        while (sda_drv_low && !scl_drv_low && n < 50) begin @(negedge clk); n++; end
        chk(n == HOLD, "R5 hold", n, HOLD);
        chk(ctl_rd[4] == 1'b0, "R5 sto clr", ctl_rd[4], 0);
        chk(ctl_rd[7] == 1'b0, "R5 no flag", ctl_rd[7], 0);
        repeat (5) @(negedge clk);
        chk(bus_busy == 1'b0, "R3 busy clr", bus_busy, 0);

        // R3 START deferred while another master holds the bus
        ext_sda = 1'b0;
        repeat (5) @(negedge clk);
        chk(bus_busy == 1'b1, "R3 foreign start", bus_busy, 1);
        cpu_ctl(8'hA4);
        n = 0;
        repeat (20) begin @(negedge clk); n += sda_drv_low; end
        chk(n == 0, "R3 deferred", n, 0);
        ext_sda = 1'b1;
        n = 0;
        while (!sda_drv_low && n < 10) begin @(negedge clk); n++; end
        chk(sda_drv_low == 1'b1, "R3 start after stop", sda_drv_low, 1);
        n = 0;
        while (!scl_drv_low && n < 50) begin @(negedge clk); n++; end

        // R10 disable aborts ownership
        cpu_ctl(8'h20);
        chk(!scl_drv_low && !sda_drv_low, "R10 release", {scl_drv_low, sda_drv_low}, 0);
        @(negedge clk);
        chk(bus_busy == 1'b0, "R10 busy", bus_busy, 0);
        repeat (3) @(negedge clk);
        chk(!scl_drv_low && !sda_drv_low, "R10 stays off", {scl_drv_low, sda_drv_low}, 0);
        cpu_ctl(8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule